// File: doc/BRIEF.md
# Always-Running Downcount Watchdog with Armed Reset Pulse

This block is a watchdog timer whose counter never stops. Software loads an 8-bit preset through a byte-wide register port. Each preset write reloads the counter and restarts the countdown. The counter then steps down once per time unit. The unit is either one second or one minute, and a time-base control bit picks which. A clock prescaler, set by a parameter, derives the seconds from the system clock. A second parameter sets how many seconds make up one minute, so a simulation can use short periods.

When the count reaches zero, the block raises an event flag and the counter stays at zero. Software clears the flag by writing a one to it. A system reset pulse of fixed width follows only when the flag goes from low to high while an output-arm bit is set. Clearing the arm bit therefore works as a logical stop: the countdown still runs, but no reset results. Arming after the flag has already risen has no effect. A further expiry while the flag is still set also has no effect.

Top module: `wdog_gated`

## Requirements
- R1: Register map, selected by a 2-bit address. Address 0 holds the 8-bit preset and reads back the last value written. Address 1 is control, with bit 0 as the time base (1 = seconds, 0 = minutes). Address 2 holds the arm bit in bit 1. Address 3 holds the event flag in bit 0. Every other bit reads as 0.
- R2: A write to address 0 loads the counter with the written value and restarts the unit divider, so the next expiry comes a full preset count of units later. A write to control does not restart the countdown.
- R3: With a preset of P between 1 and 255, expiry occurs P units after the preset write. A preset of 0 never expires.
- R4: The counter runs whatever the arm bit holds. An expiry with the arm bit clear still sets the event flag.
- R5: On expiry the event flag sets. Writing 1 to bit 0 of address 3 clears it, and writing 0 there leaves it unchanged. If an expiry and a clear fall in the same cycle, the expiry wins.
- R6: When the event flag rises while the arm bit is 1, the reset output goes high in the same cycle that the flag first reads 1. It stays high for exactly RST_PULSE clock cycles.
- R7: No reset pulse follows when the arm bit is set after the flag has risen. No reset pulse follows an expiry while the flag is still set.
- R8: One second is CLKS_PER_SEC clock cycles. One minute is SECS_PER_MIN seconds.
- R9: After expiry the counter holds at zero until the preset is written again. No further expiry occurs in that time.
- R10: After reset the preset and counter hold DEF_PRESET, the time base holds DEF_SEC_BASE, the arm bit is 0, the event flag is 0 and the reset output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the addressed register, combinational |
| wdt_event_o | output | 1 | Expiry event flag |
| wdt_rst_o | output | 1 | System reset pulse |

## Verification
The assertions take each write strobe to last one cycle with a stable address and data. They also take CLKS_PER_SEC and RST_PULSE to be at least 2 wherever a property checks tick spacing or pulse length. The bench keeps to these assumptions. It drives every write for exactly one cycle on the falling edge and uses a short prescaler and a short minute. That keeps every expiry, in both time bases, within a few dozen cycles. Directed sequences take the block through each arming order, including early and late arming and a repeat expiry. A behavioural model checks the outputs and the read data on every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    REG_PRESET = 2'd0,
    REG_CTRL   = 2'd1,
    REG_ARM    = 2'd2,
    REG_EVENT  = 2'd3
  } wdog_reg_e;

  localparam int unsigned TB_SEC_BIT = 0;
  localparam int unsigned ARM_BIT    = 1;
  localparam int unsigned EVT_BIT    = 0;

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int unsigned CLKS_PER_SEC = 50000000,
  parameter int unsigned SECS_PER_MIN = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic sec_base_i,
  output logic unit_tick_o
);

  localparam int unsigned PRE_W = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam int unsigned MIN_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_SEC - 1);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(SECS_PER_MIN - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MIN_W-1:0] min_q, min_d;
  logic             sec_tick;
  logic             min_wrap;

  assign sec_tick = (pre_q == PRE_LAST);
  assign min_wrap = (min_q == MIN_LAST);

  always_comb begin
    pre_d = pre_q;
    min_d = min_q;
    if (restart_i) begin
      pre_d = '0;
      min_d = '0;
    end else begin
      pre_d = sec_tick ? '0 : pre_q + 1'b1;
      if (sec_tick) begin
        min_d = min_wrap ? '0 : min_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      min_q <= '0;
    end else begin
      pre_q <= pre_d;
      min_q <= min_d;
    end
  end

  assign unit_tick_o = sec_base_i ? sec_tick : (sec_tick && min_wrap);

  generate
    if (CLKS_PER_SEC > 1) begin : g_gap_chk
      assert_tick_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unit_tick_o |=> !unit_tick_o);
    end
  endgenerate

endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned DEF_PRESET = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             unit_tick_i,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_DEF = CNT_W'(DEF_PRESET);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign expire_o = !load_i && unit_tick_i && (cnt_q == CNT_ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (unit_tick_i && !cnt_zero) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_DEF;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assert_hold_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_zero && !load_i) |=> (cnt_q == '0));

  assert_steady_between_units_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !unit_tick_i) |=> $stable(cnt_q));

  assert_no_expire_at_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_zero |-> !expire_o);

endmodule

// File: rtl/wdog_evt_rst.sv
module wdog_evt_rst #(
  parameter int unsigned RST_PULSE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clear_i,
  input  logic arm_i,
  output logic event_o,
  output logic rst_o
);

  localparam int unsigned PW = $clog2(RST_PULSE + 1);
  localparam logic [PW-1:0] PULSE_LEN = PW'(RST_PULSE);

  logic          evt_q, evt_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic          fire;

  assign fire = expire_i && !evt_q && arm_i;

  always_comb begin
    evt_d = evt_q;
    if (expire_i) begin
      evt_d = 1'b1;
    end else if (clear_i) begin
      evt_d = 1'b0;
    end
  end

  always_comb begin
    pulse_d = pulse_q;
    if (fire) begin
      pulse_d = PULSE_LEN;
    end else if (pulse_q != '0) begin
      pulse_d = pulse_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q   <= 1'b0;
      pulse_q <= '0;
    end else begin
      evt_q   <= evt_d;
      pulse_q <= pulse_d;
    end
  end

  assign event_o = evt_q;
  assign rst_o   = (pulse_q != '0);

  assert_rst_on_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $rose(event_o));

  assert_set_on_expire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> event_o);

  assert_clear_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !expire_i) |=> !event_o);

  assert_no_rst_flag_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !$rose(rst_o));

  assert_no_rst_unarmed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !$rose(rst_o));

  generate
    if (RST_PULSE > 1) begin : g_width_chk
      assert_pulse_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_o) |=> rst_o);
    end
  endgenerate

endmodule

// File: rtl/wdog_gated.sv
module wdog_gated #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLKS_PER_SEC = 50000000,
  parameter int unsigned SECS_PER_MIN = 60,
  parameter int unsigned RST_PULSE    = 16,
  parameter int unsigned DEF_PRESET   = 60,
  parameter bit          DEF_SEC_BASE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              wdt_event_o,
  output logic              wdt_rst_o
);
  import wdog_pkg::*;

  localparam logic [DATA_W-1:0] PRESET_DEF = DATA_W'(DEF_PRESET);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  wdog_reg_e         addr_e;
  logic              wr_preset, wr_ctrl, wr_arm, wr_event;
  logic [DATA_W-1:0] preset_q, preset_d;
  logic              sec_base_q, sec_base_d;
  logic              arm_q, arm_d;
  logic              unit_tick;
  logic              expire;
  logic              evt_clear;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign addr_e    = wdog_reg_e'(reg_addr_i);
  assign wr_preset = reg_we_i && (addr_e == REG_PRESET);
  assign wr_ctrl   = reg_we_i && (addr_e == REG_CTRL);
  assign wr_arm    = reg_we_i && (addr_e == REG_ARM);
  assign wr_event  = reg_we_i && (addr_e == REG_EVENT);
  assign evt_clear = wr_event && reg_wdata_i[EVT_BIT];

  always_comb begin
    preset_d   = preset_q;
    sec_base_d = sec_base_q;
    arm_d      = arm_q;
    if (wr_preset) preset_d   = reg_wdata_i;
    if (wr_ctrl)   sec_base_d = reg_wdata_i[TB_SEC_BIT];
    if (wr_arm)    arm_d      = reg_wdata_i[ARM_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      preset_q   <= PRESET_DEF;
      sec_base_q <= DEF_SEC_BASE;
      arm_q      <= 1'b0;
    end else begin
      preset_q   <= preset_d;
      sec_base_q <= sec_base_d;
      arm_q      <= arm_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr_e)
      REG_PRESET: reg_rdata_o             = preset_q;
      REG_CTRL:   reg_rdata_o[TB_SEC_BIT] = sec_base_q;
      REG_ARM:    reg_rdata_o[ARM_BIT]    = arm_q;
      REG_EVENT:  reg_rdata_o[EVT_BIT]    = wdt_event_o;
      default:    reg_rdata_o             = '0;
    endcase
  end

  wdog_tick_gen #(
    .CLKS_PER_SEC (CLKS_PER_SEC),
    .SECS_PER_MIN (SECS_PER_MIN)
  ) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .restart_i   (wr_preset),
    .sec_base_i  (sec_base_q),
    .unit_tick_o (unit_tick)
  );

  wdog_downcount #(
    .CNT_W      (DATA_W),
    .DEF_PRESET (DEF_PRESET)
  ) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .load_i      (wr_preset),
    .load_val_i  (reg_wdata_i),
    .unit_tick_i (unit_tick),
    .expire_o    (expire)
  );

  wdog_evt_rst #(
    .RST_PULSE (RST_PULSE)
  ) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .expire_i (expire),
    .clear_i  (evt_clear),
    .arm_i    (arm_q),
    .event_o  (wdt_event_o),
    .rst_o    (wdt_rst_o)
  );

  assert_preset_readback_R1: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    wr_preset |=> (preset_q == $past(reg_wdata_i)));

  assert_expire_unit_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    wr_preset |-> !expire);

endmodule

// File: tb/wdog_gated_bench.sv
module wdog_gated_bench;

  localparam int CPS   = 4;
  localparam int SPM   = 3;
  localparam int PULSE = 3;
  localparam int DEFP  = 2;

  logic       clk;
  logic       rst_n;
  logic       we;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       evt;
  logic       wrst;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  wdog_gated #(
    .DATA_W       (8),
    .CLKS_PER_SEC (CPS),
    .SECS_PER_MIN (SPM),
    .RST_PULSE    (PULSE),
    .DEF_PRESET   (DEFP),
    .DEF_SEC_BASE (1'b1)
  ) u_wdog_gated (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .wdt_event_o (evt),
    .wdt_rst_o   (wrst)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference model
  int m_sync, m_pre, m_min, m_cnt, m_ev, m_pulse, m_tb, m_arm, m_preset;
  int pulses, last_width, cur_width;
  bit prev_rst;

  task automatic model_reset();
    m_pre = 0; m_min = 0; m_cnt = DEFP; m_ev = 0; m_pulse = 0;
    m_tb = 1; m_arm = 0; m_preset = DEFP;
  endtask

  initial begin
    m_sync = 0; pulses = 0; last_width = 0; cur_width = 0; prev_rst = 0;
    model_reset();
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0;
      model_reset();
    end else begin
      if (m_sync >= 2) begin
        bit sec_t, unit_t, load, exp_now, clr;
        sec_t   = (m_pre == CPS - 1);
        unit_t  = (m_tb != 0) ? sec_t : (sec_t && m_min == SPM - 1);
        load    = we && addr == 2'd0;
        exp_now = !load && unit_t && m_cnt == 1;
        clr     = we && addr == 2'd3 && wdata[0];
        if (exp_now && m_ev == 0 && m_arm != 0) m_pulse = PULSE;
        else if (m_pulse > 0) m_pulse = m_pulse - 1;
        if (exp_now) m_ev = 1;
        else if (clr) m_ev = 0;
        if (load) begin
          m_pre = 0; m_min = 0; m_cnt = int'(wdata); m_preset = int'(wdata);
        end else begin
          if (sec_t) m_min = (m_min == SPM - 1) ? 0 : m_min + 1;
          m_pre = sec_t ? 0 : m_pre + 1;
          if (unit_t && m_cnt != 0) m_cnt = m_cnt - 1;
        end
        if (we && addr == 2'd1) m_tb  = int'(wdata[0]);
        if (we && addr == 2'd2) m_arm = int'(wdata[1]);
      end
      if (m_sync < 2) m_sync = m_sync + 1;
    end
  end

  function automatic logic [7:0] model_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return 8'(m_preset);
      2'd1:    return {7'b0, m_tb[0]};
      2'd2:    return {6'b0, m_arm[0], 1'b0};
      default: return {7'b0, m_ev[0]};
    endcase
  endfunction

  // per-cycle comparison, 5 ns after the rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      n_tests++;
      if (wrst !== (m_pulse != 0)) begin
        n_fail++;
        $display("FAIL R6 cycle reset out: got %0b expected %0b", wrst, m_pulse != 0);
      end
      n_tests++;
      if (evt !== m_ev[0]) begin
        n_fail++;
        $display("FAIL R5 cycle event flag: got %0b expected %0b", evt, m_ev[0]);
      end
      n_tests++;
      if (rdata !== model_rdata(addr)) begin
        n_fail++;
        $display("FAIL R1 cycle read data addr %0d: got %0h expected %0h",
                 addr, rdata, model_rdata(addr));
      end
      if (wrst && !prev_rst) begin
        pulses++;
        cur_width = 0;
      end
      if (wrst) cur_width++;
      if (!wrst && prev_rst) last_width = cur_width;
      prev_rst = wrst;
    end
  end

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(rdata === exp, req, int'(rdata), int'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int p0;
    rst_n = 1'b0; we = 1'b0; addr = 2'd0; wdata = 8'h00;
    idle(4);
    rst_n = 1'b1;
    // R10: reset state, checked before the default preset runs out
    rd_chk(2'd0, 8'(DEFP), "R10 preset reset value");
    rd_chk(2'd1, 8'h01, "R10 time base reset value");
    rd_chk(2'd2, 8'h00, "R10 arm reset value");
    rd_chk(2'd3, 8'h00, "R10 event reset value");
    check(wrst == 1'b0, "R10 reset output low", int'(wrst), 0);

    // R4: the default preset expires while unarmed, flag sets, no pulse
    idle(20);
    rd_chk(2'd3, 8'h01, "R4 event set while unarmed");
    check(pulses == 0, "R4 no pulse while unarmed", pulses, 0);

    // R5: writing 0 keeps the flag, writing 1 clears it
    wr(2'd3, 8'h00);
    rd_chk(2'd3, 8'h01, "R5 write zero keeps flag");
    wr(2'd3, 8'h01);
    rd_chk(2'd3, 8'h00, "R5 write one clears flag");

    // R9: the counter stays at zero, no new expiry
    idle(30);
    rd_chk(2'd3, 8'h00, "R9 no expiry after zero");

    // R3: a preset of 0 never expires
    wr(2'd0, 8'h00);
    idle(30);
    rd_chk(2'd3, 8'h00, "R3 preset zero never expires");

    // R6: armed expiry gives one pulse of PULSE cycles
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h03);
    idle(9);
    rd_chk(2'd3, 8'h00, "R3 no expiry before three units");
    idle(12);
    rd_chk(2'd3, 8'h01, "R6 event after three units");
    check(pulses == 1, "R6 one pulse", pulses, 1);
    check(last_width == PULSE, "R6 pulse width", last_width, PULSE);

    // R7: arming after the flag rose gives no pulse
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h01);
    idle(8);
    rd_chk(2'd3, 8'h01, "R7 unarmed expiry set flag");
    wr(2'd2, 8'h02);
    idle(10);
    check(pulses == 1, "R7 late arm gives no pulse", pulses, 1);

    // R7: a second expiry while the flag is still set gives no pulse
    wr(2'd0, 8'h01);
    idle(10);
    check(pulses == 1, "R7 expiry with flag held gives no pulse", pulses, 1);

    // R2: repeated preset writes keep the countdown from finishing
    wr(2'd3, 8'h01);
    for (int i = 0; i < 5; i++) begin
      wr(2'd0, 8'h03);
      idle(6);
    end
    rd_chk(2'd3, 8'h00, "R2 reloads prevent expiry");
    check(pulses == 1, "R2 no pulse while reloading", pulses, 1);
    wr(2'd1, 8'h01);
    idle(12);
    rd_chk(2'd3, 8'h01, "R2 control write does not restart");
    check(pulses == 2, "R2 pulse after reloads stop", pulses, 2);

    // R8: minute base, preset 1 = SPM*CPS cycles
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h00);
    p0 = pulses;
    wr(2'd0, 8'h01);
    idle(9);
    rd_chk(2'd3, 8'h00, "R8 no expiry before one minute");
    idle(3);
    rd_chk(2'd3, 8'h01, "R8 expiry at one minute");
    check(pulses == p0 + 1, "R8 pulse at one minute", pulses, p0 + 1);

    // R1: unused bits read zero
    wr(2'd1, 8'hFE);
    rd_chk(2'd1, 8'h00, "R1 control unused bits");
    wr(2'd2, 8'hFD);
    rd_chk(2'd2, 8'h00, "R1 arm unused bits");
    wr(2'd1, 8'hFF);
    rd_chk(2'd1, 8'h01, "R1 control bit 0");
    wr(2'd2, 8'hFF);
    rd_chk(2'd2, 8'h02, "R1 arm bit 1");
    wr(2'd0, 8'hA5);
    rd_chk(2'd0, 8'hA5, "R1 preset readback");

    idle(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule